// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the operand-address fields of a decoded memory instruction into bus-ready addresses. It adds up to three 16-bit terms (a base pointer, an index pointer and a displacement) into an effective offset. It then picks the segment register that applies to that offset, either by the default rule or by an explicit override. The segment value, shifted left by four bits, is added to the offset to form a 20-bit physical address.

The result appears one clock after a request, together with per-lane byte enables for a 16-bit data bus. A word whose offset is odd straddles two bus words, so the block issues it as two byte cycles on consecutive clocks. The first cycle drives the odd address with only the upper lane enabled. The second cycle drives offset plus one, in the same segment, with only the lower lane enabled. A bus sequencer downstream reads the two-cycle flag to know that a second cycle follows.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment value × 16 + effective offset) modulo 2^20; for example segment 3480h with offset 1234h gives 35A34h.
- R2: The effective offset is the 16-bit sum, modulo 2^16, of the terms picked by `mode`: 0 disp; 1 BX+disp; 2 BP+disp; 3 SI+disp; 4 DI+disp; 5 BX+SI+disp; 6 BX+DI+disp; 7 BP+SI+disp.
- R3: With no override, the segment is the stack segment (`seg_used`=2) for modes 2 and 7, which use BP, and the data segment (`seg_used`=3) for every other mode.
- R4: When `ovr_en` is 1, `ovr_sel` selects the segment instead of the default rule (0 extra, 1 code, 2 stack, 3 data), and `seg_used` reports that code.
- R5: A request sampled on a clock edge shows `bus_valid`=1 from that edge; with no request and no pending second cycle, `bus_valid`, `byte_en`, `two_cycle` and `second_phase` are 0 after the next edge.
- R6: A word access at an even offset is one cycle with `byte_en`=11 and `two_cycle`=0.
- R7: A word access at an odd offset takes two cycles. The first has `byte_en`=10, `two_cycle`=1 and `second_phase`=0. The second follows at once with `byte_en`=01, `second_phase`=1, the same `seg_used`, and the address built from offset plus one.
- R8: A byte access is one cycle with `byte_en`=01 at an even offset and 10 at an odd offset, and `two_cycle`=0.
- R9: A request presented while the first cycle of a split word is on the outputs is ignored; the second cycle still follows, and then the block goes idle.
- R10: During and right after reset, `bus_valid`, `byte_en`, `two_cycle` and `second_phase` are 0.
- R11: When the odd offset of a split word is FFFFh, the second cycle uses offset 0000h within the same segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request this cycle |
| mode | input | 3 | Addressing-mode selector (R2 encoding) |
| word_acc | input | 1 | 1 for a 16-bit access, 0 for a byte |
| reg_bx | input | 16 | BX base register |
| reg_bp | input | 16 | BP base register |
| reg_si | input | 16 | SI index register |
| reg_di | input | 16 | DI index register |
| disp | input | 16 | Displacement |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment code |
| bus_valid | output | 1 | A bus cycle address is presented |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Segment code applied |
| byte_en | output | 2 | Lane enables, bit 1 upper lane, bit 0 lower lane |
| two_cycle | output | 1 | Current access is split in two cycles |
| second_phase | output | 1 | Second cycle of a split access |

## Verification
The two functions that collide are the automatic second cycle of an odd-address word and the acceptance of a new request. The bench raises a fresh request with a different mode, segment override and offset in the very cycle the first half of a split word is on the outputs. It then judges that the next cycle still carries the original segment with offset plus one on the lower lane, and that the cycle after is idle, so the newer request was dropped rather than merged or queued.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic [1:0] {
    SEG_EXTRA = 2'd0,
    SEG_CODE  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_DATA  = 2'd3
  } seg_code_e;

  typedef enum logic [2:0] {
    AM_DISP    = 3'd0,
    AM_BX      = 3'd1,
    AM_BP      = 3'd2,
    AM_SI      = 3'd3,
    AM_DI      = 3'd4,
    AM_BX_SI   = 3'd5,
    AM_BX_DI   = 3'd6,
    AM_BP_SI   = 3'd7
  } addr_mode_e;

  localparam int NUM_SEGS = 4;
  localparam int LANES    = 2;
endpackage

// File: rtl/sag_offset.sv
module sag_offset #(
  parameter int OFS_W = 16
) (
  input  logic [2:0]       mode,
  input  logic [OFS_W-1:0] reg_bx,
  input  logic [OFS_W-1:0] reg_bp,
  input  logic [OFS_W-1:0] reg_si,
  input  logic [OFS_W-1:0] reg_di,
  input  logic [OFS_W-1:0] disp,
  output logic [OFS_W-1:0] eff_ofs,
  output logic             uses_bp
);
  import sag_pkg::*;

  function automatic logic [OFS_W-1:0] sum3(input logic [OFS_W-1:0] a,
                                            input logic [OFS_W-1:0] b,
                                            input logic [OFS_W-1:0] c);
    return a + b + c;
  endfunction

  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] index_term;

  always_comb begin
    base_term  = '0;
    index_term = '0;
    uses_bp    = 1'b0;
    unique case (addr_mode_e'(mode))
      AM_DISP:  ;
      AM_BX:    base_term = reg_bx;
      AM_BP:    begin base_term = reg_bp; uses_bp = 1'b1; end
      AM_SI:    index_term = reg_si;
      AM_DI:    index_term = reg_di;
      AM_BX_SI: begin base_term = reg_bx; index_term = reg_si; end
      AM_BX_DI: begin base_term = reg_bx; index_term = reg_di; end
      AM_BP_SI: begin base_term = reg_bp; index_term = reg_si; uses_bp = 1'b1; end
      default:  ;
    endcase
  end

  assign eff_ofs = sum3(base_term, index_term, disp);
endmodule

// File: rtl/sag_segsel.sv
module sag_segsel #(
  parameter int SEG_W = 16
) (
  input  logic             uses_bp,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  output logic [1:0]       seg_code,
  output logic [SEG_W-1:0] seg_val
);
  import sag_pkg::*;

  logic [SEG_W-1:0] seg_bank [NUM_SEGS];
  logic [1:0]       dflt_code;

  assign seg_bank[SEG_EXTRA] = seg_es;
  assign seg_bank[SEG_CODE]  = seg_cs;
  assign seg_bank[SEG_STACK] = seg_ss;
  assign seg_bank[SEG_DATA]  = seg_ds;

  assign dflt_code = uses_bp ? SEG_STACK : SEG_DATA;
  assign seg_code  = ovr_en ? ovr_sel : dflt_code;
  assign seg_val   = seg_bank[seg_code];
endmodule

// File: rtl/sag_seq.sv
module sag_seq #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              word_acc,
  input  logic [OFS_W-1:0]  eff_ofs,
  input  logic [1:0]        seg_code,
  input  logic [OFS_W-1:0]  seg_val,
  output logic              bus_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [1:0]        seg_used,
  output logic [1:0]        byte_en,
  output logic              two_cycle,
  output logic              second_phase,
  output logic              split_pending,
  output logic              req_taken
);
  function automatic logic [PHYS_W-1:0] phys_of(input logic [OFS_W-1:0] seg,
                                                input logic [OFS_W-1:0] ofs);
    logic [PHYS_W-1:0] shifted;
    shifted = PHYS_W'(seg) << SEG_SHIFT;
    return shifted + PHYS_W'(ofs);
  endfunction

  logic [OFS_W-1:0] held_seg;
  logic [OFS_W-1:0] held_ofs;
  logic [OFS_W-1:0] next_ofs;
  logic             odd_word;

  assign split_pending = bus_valid & two_cycle & ~second_phase;
  assign req_taken     = req_valid & ~split_pending;
  assign odd_word      = word_acc & eff_ofs[0];
  assign next_ofs      = held_ofs + OFS_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid    <= 1'b0;
      phys_addr    <= '0;
      seg_used     <= '0;
      byte_en      <= '0;
      two_cycle    <= 1'b0;
      second_phase <= 1'b0;
      held_seg     <= '0;
      held_ofs     <= '0;
    end else if (split_pending) begin
      bus_valid    <= 1'b1;
      phys_addr    <= phys_of(held_seg, next_ofs);
      byte_en      <= 2'b01;
      second_phase <= 1'b1;
      held_ofs     <= next_ofs;
    end else if (req_taken) begin
      bus_valid    <= 1'b1;
      phys_addr    <= phys_of(seg_val, eff_ofs);
      seg_used     <= seg_code;
      two_cycle    <= odd_word;
      second_phase <= 1'b0;
      held_seg     <= seg_val;
      held_ofs     <= eff_ofs;
      if (word_acc && !eff_ofs[0]) byte_en <= 2'b11;
      else if (eff_ofs[0])         byte_en <= 2'b10;
      else                         byte_en <= 2'b01;
    end else begin
      bus_valid    <= 1'b0;
      byte_en      <= '0;
      two_cycle    <= 1'b0;
      second_phase <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic              word_acc,
  input  logic [OFS_W-1:0]  reg_bx,
  input  logic [OFS_W-1:0]  reg_bp,
  input  logic [OFS_W-1:0]  reg_si,
  input  logic [OFS_W-1:0]  reg_di,
  input  logic [OFS_W-1:0]  disp,
  input  logic [OFS_W-1:0]  seg_es,
  input  logic [OFS_W-1:0]  seg_cs,
  input  logic [OFS_W-1:0]  seg_ss,
  input  logic [OFS_W-1:0]  seg_ds,
  input  logic              ovr_en,
  input  logic [1:0]        ovr_sel,
  output logic              bus_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic [1:0]        seg_used,
  output logic [1:0]        byte_en,
  output logic              two_cycle,
  output logic              second_phase
);
  logic [OFS_W-1:0] eff_ofs;
  logic             uses_bp;
  logic [1:0]       seg_code;
  logic [OFS_W-1:0] seg_val;
  logic             split_pending;
  logic             req_taken;

  sag_offset #(.OFS_W(OFS_W)) u_offset (
    .mode    (mode),
    .reg_bx  (reg_bx),
    .reg_bp  (reg_bp),
    .reg_si  (reg_si),
    .reg_di  (reg_di),
    .disp    (disp),
    .eff_ofs (eff_ofs),
    .uses_bp (uses_bp)
  );

  sag_segsel #(.SEG_W(OFS_W)) u_segsel (
    .uses_bp  (uses_bp),
    .ovr_en   (ovr_en),
    .ovr_sel  (ovr_sel),
    .seg_es   (seg_es),
    .seg_cs   (seg_cs),
    .seg_ss   (seg_ss),
    .seg_ds   (seg_ds),
    .seg_code (seg_code),
    .seg_val  (seg_val)
  );

  sag_seq #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .word_acc      (word_acc),
    .eff_ofs       (eff_ofs),
    .seg_code      (seg_code),
    .seg_val       (seg_val),
    .bus_valid     (bus_valid),
    .phys_addr     (phys_addr),
    .seg_used      (seg_used),
    .byte_en       (byte_en),
    .two_cycle     (two_cycle),
    .second_phase  (second_phase),
    .split_pending (split_pending),
    .req_taken     (req_taken)
  );
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
  parameter int PHYS_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_taken,
  input logic              split_pending,
  input logic              bus_valid,
  input logic [PHYS_W-1:0] phys_addr,
  input logic [1:0]        seg_used,
  input logic [1:0]        byte_en,
  input logic              two_cycle,
  input logic              second_phase
);
  // R7: first half of a split is always followed by the second half
  a_r7_split_follows: assert property (@(posedge clk) disable iff (!rst_n)
    split_pending |=> (bus_valid && second_phase && byte_en == 2'b01));

  // R7: first half drives an odd address on the upper lane
  a_r7_first_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
    split_pending |-> (phys_addr[0] && byte_en == 2'b10));

  // R7: second half keeps the segment and lands on an even address
  a_r7_second_same_seg: assert property (@(posedge clk) disable iff (!rst_n)
    second_phase |-> (seg_used == $past(seg_used) && !phys_addr[0] && two_cycle));

  // R9: no request is accepted while a split is pending
  a_r9_no_take_when_split: assert property (@(posedge clk) disable iff (!rst_n)
    split_pending |-> !req_taken);

  // R5: idle outputs carry no lane enables
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (byte_en == 2'b00 && !two_cycle && !second_phase));

  // R5: a taken request yields a bus cycle on the next edge
  a_r5_take_gives_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> (bus_valid && !second_phase));

  // R8: a single-cycle access enables at least one lane
  a_r8_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (byte_en != 2'b00));
endmodule

bind seg_addr_gen sag_checker #(.PHYS_W(PHYS_W)) u_sag_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_taken     (req_taken),
  .split_pending (split_pending),
  .bus_valid     (bus_valid),
  .phys_addr     (phys_addr),
  .seg_used      (seg_used),
  .byte_en       (byte_en),
  .two_cycle     (two_cycle),
  .second_phase  (second_phase)
);

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  mode;
  logic        word_acc;
  logic [15:0] reg_bx, reg_bp, reg_si, reg_di, disp;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_en;
  logic [1:0]  ovr_sel;
  logic        bus_valid;
  logic [19:0] phys_addr;
  logic [1:0]  seg_used;
  logic [1:0]  byte_en;
  logic        two_cycle;
  logic        second_phase;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .word_acc(word_acc), .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si),
    .reg_di(reg_di), .disp(disp), .seg_es(seg_es), .seg_cs(seg_cs),
    .seg_ss(seg_ss), .seg_ds(seg_ds), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
    .bus_valid(bus_valid), .phys_addr(phys_addr), .seg_used(seg_used),
    .byte_en(byte_en), .two_cycle(two_cycle), .second_phase(second_phase)
  );

  typedef struct packed {
    logic [2:0]  m;
    logic        w;
    logic [15:0] bx, bp, si, di, dp;
    logic        oe;
    logic [1:0]  os;
    logic [1:0]  exp_seg;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0300, 1'b0, 2'd0, 2'd3},
    '{3'd1, 1'b1, 16'h1200, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 1'b0, 2'd0, 2'd3},
    '{3'd2, 1'b0, 16'h0000, 16'h0010, 16'h0000, 16'h0000, 16'h0001, 1'b0, 2'd0, 2'd2},
    '{3'd3, 1'b1, 16'h0000, 16'h0000, 16'h0310, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd3},
    '{3'd4, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0022, 16'h0000, 1'b0, 2'd0, 2'd3},
    '{3'd5, 1'b1, 16'h1000, 16'h0000, 16'h0FFF, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd3},
    '{3'd6, 1'b1, 16'h8000, 16'h0000, 16'h0000, 16'h8000, 16'h0001, 1'b0, 2'd0, 2'd3},
    '{3'd7, 1'b1, 16'h0000, 16'hFFFE, 16'h0001, 16'h0000, 16'h0001, 1'b0, 2'd0, 2'd2},
    '{3'd2, 1'b1, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd0, 2'd0},
    '{3'd1, 1'b0, 16'h0055, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd1, 2'd1},
    '{3'd7, 1'b1, 16'h0000, 16'h0100, 16'h0021, 16'h0000, 16'h0000, 1'b1, 2'd3, 2'd3},
    '{3'd0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 2'd2, 2'd2},
    '{3'd1, 1'b1, 16'h9000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd3}
  };

  function automatic logic [15:0] model_ofs(input vec_t v);
    logic [16:0] acc;
    acc = {1'b0, v.dp};
    if (v.m == 3'd1 || v.m == 3'd5 || v.m == 3'd6) acc = acc + {1'b0, v.bx};
    if (v.m == 3'd2 || v.m == 3'd7)                acc = acc + {1'b0, v.bp};
    if (v.m == 3'd3 || v.m == 3'd5 || v.m == 3'd7) acc = acc + {1'b0, v.si};
    if (v.m == 3'd4 || v.m == 3'd6)                acc = acc + {1'b0, v.di};
    return acc[15:0];
  endfunction

  function automatic logic [15:0] seg_value(input logic [1:0] c);
    case (c)
      2'd0: return seg_es;
      2'd1: return seg_cs;
      2'd2: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  function automatic logic [19:0] model_phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] full;
    full = {1'b0, s, 4'h0} + {5'h00, o};
    return full[19:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    mode = v.m; word_acc = v.w; reg_bx = v.bx; reg_bp = v.bp;
    reg_si = v.si; reg_di = v.di; disp = v.dp; ovr_en = v.oe; ovr_sel = v.os;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    seg_es = 16'h4900; seg_cs = 16'h2000; seg_ss = 16'h3400; seg_ds = 16'hF800;
    drive(TBL[0]);
    req_valid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset holds outputs quiet even with a request present
    check("R10 bus_valid", 32'(bus_valid), 32'd0);
    check("R10 byte_en", 32'(byte_en), 32'd0);
    check("R10 split flags", 32'({two_cycle, second_phase}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1;
    check("R10 after reset", 32'(bus_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] ofs;
      logic [15:0] sv;
      logic        odd_w;
      @(negedge clk);
      drive(TBL[i]);
      req_valid = 1'b1;
      ofs   = model_ofs(TBL[i]);
      sv    = seg_value(TBL[i].exp_seg);
      odd_w = TBL[i].w & ofs[0];
      @(posedge clk); #1;
      req_valid = 1'b0;
      check("R5 valid", 32'(bus_valid), 32'd1);
      check("R1 R2 phys", 32'(phys_addr), 32'(model_phys(sv, ofs)));
      check("R3 R4 segment", 32'(seg_used), 32'(TBL[i].exp_seg));
      if (odd_w) begin
        check("R7 first lanes", 32'({two_cycle, second_phase, byte_en}), 32'b1010);
        @(posedge clk); #1;
        check("R7 R11 second phys", 32'(phys_addr), 32'(model_phys(sv, ofs + 16'd1)));
        check("R7 second lanes", 32'({bus_valid, second_phase, byte_en}), 32'b1101);
        check("R7 second segment", 32'(seg_used), 32'(TBL[i].exp_seg));
      end else if (TBL[i].w) begin
        check("R6 even word", 32'({two_cycle, byte_en}), 32'b011);
      end else begin
        check("R8 byte lanes", 32'({two_cycle, byte_en}), ofs[0] ? 32'b010 : 32'b001);
      end
      @(posedge clk); #1;
      check("R5 idle", 32'({bus_valid, byte_en}), 32'd0);
    end

    // R1: literal example 3480h:1234h
    @(negedge clk);
    seg_ss = 16'h3480;
    drive('{3'd2, 1'b0, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd2});
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R1 example", 32'(phys_addr), 32'h35A34);

    // R9: new request during first half of a split word is dropped
    @(negedge clk);
    drive('{3'd3, 1'b1, 16'h0000, 16'h0000, 16'h0101, 16'h0000, 16'h0000, 1'b0, 2'd0, 2'd3});
    req_valid = 1'b1;
    @(posedge clk); #1;
    check("R9 first half", 32'({two_cycle, second_phase, byte_en}), 32'b1010);
    drive('{3'd2, 1'b1, 16'h0000, 16'h0200, 16'h0000, 16'h0000, 16'h0000, 1'b1, 2'd1, 2'd1});
    @(posedge clk); #1;
    req_valid = 1'b0;
    check("R9 second half kept", 32'(phys_addr), 32'(model_phys(seg_ds, 16'h0102)));
    check("R9 segment kept", 32'(seg_used), 32'd3);
    @(posedge clk); #1;
    check("R9 request dropped", 32'(bus_valid), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule